// File: doc/BRIEF.md
# Battery-Assist Mode Request Decoder

This block sits behind the command parser of a passive RFID tag and decides when the reader has asked the tag to connect its battery. A tag leaves the factory with the battery disconnected, and it runs only from the RF field. The battery stays disconnected until the reader sends one of two special forms of ordinary commands.

The first form is a Select aimed at a reserved bank/pointer pair that carries the tag's complete EPC as its mask. The second form is a Write to a reserved word address, and its data word plays no part in the decision. When either form is accepted, the block sets a sticky battery-connect flag and raises a one-cycle pulse that marks the transition. It also patches the flag into one bit of the protocol control word, so the reader can read back the connection state.

The block takes one parsed command record per cycle, qualified by a valid strobe, together with the tag's current EPC value and its length in bits. The decision is registered, so it appears one clock after the record is sampled.

Top module: `batt_assist_request`

## Requirements
- R1: After a synchronous active-low reset, `batt_connect` and `batt_connect_pulse` are 0, and bit `PC_STATUS_BIT` (default 4) of `pc_word_out` is 0.
- R2: A valid Select record (`cmd_kind` = 2'b01) is a request only if `cmd_bank` = 2'b11 and `cmd_ptr` = 16'h8140. Any other bank or pointer leaves the flag unchanged.
- R3: For the Select form, `cmd_len` must equal `tag_epc_len`, and that length must not exceed the mask width. Mask bits [len-1:0] must equal `tag_epc` bits [len-1:0]. Mask bits at or above the length are ignored. A shorter or longer length, or any differing bit inside the length, rejects the record.
- R4: A valid Write record (`cmd_kind` = 2'b10) is a request when `cmd_bank` = 2'b10 and `cmd_ptr` = 16'h0040, whatever the value of `cmd_data`. Other banks or pointers are not requests.
- R5: A record is ignored when `cmd_valid` is 0, or when `cmd_kind` is 2'b00 or 2'b11, whatever its other fields hold.
- R6: An accepted request is sampled on a rising clock edge, and `batt_connect` is 1 from that edge onward.
- R7: Once set, `batt_connect` stays 1 until reset. Further requests or non-requests have no effect on it.
- R8: `batt_connect_pulse` is 1 for exactly the one cycle in which `batt_connect` first becomes 1. Later requests do not raise it.
- R9: `pc_word_out` equals `pc_word_in`, except that bit `PC_STATUS_BIT` carries `batt_connect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command record strobe |
| cmd_kind | input | 2 | 01 Select, 10 Write, 00/11 other |
| cmd_bank | input | 2 | Memory bank field |
| cmd_ptr | input | 16 | Pointer / word address field |
| cmd_len | input | LEN_W | Select length field in bits |
| cmd_mask | input | 16*EPC_WORDS | Select mask, bit 0 aligned to EPC bit 0 |
| cmd_data | input | 16 | Write data (ignored) |
| tag_epc | input | 16*EPC_WORDS | Tag's current EPC |
| tag_epc_len | input | LEN_W | Tag's EPC length in bits |
| pc_word_in | input | 16 | Protocol control word from storage |
| batt_connect | output | 1 | Sticky battery-connect flag |
| batt_connect_pulse | output | 1 | One-cycle pulse on first set |
| pc_word_out | output | 16 | Protocol control word with status bit patched |

## Verification
The hardest case to reach from the ports is a Select with the right bank and pointer that fails the full-EPC comparison by a single bit, or by a length that is off by one. Most such records look almost correct. The bench reaches this case by sweeping every command length from 0 to the mask width against several EPC lengths. For each pair it flips each mask bit in turn, with a reset between cases, so every near-miss is shown on a clean flag. Stickiness is reached by first setting the flag and then replaying both request forms and non-requests.

// File: rtl/batt_assist_pkg.sv
// Package: shared command-kind encoding and the reserved field values that
// mark a battery-connect request.
package batt_assist_pkg;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'b00,
        KIND_SELECT = 2'b01,
        KIND_WRITE  = 2'b10,
        KIND_OTHER  = 2'b11
    } cmd_kind_e;

    localparam logic [1:0]  SEL_REQ_BANK = 2'b11;
    localparam logic [15:0] SEL_REQ_PTR  = 16'h8140;
    localparam logic [1:0]  WR_REQ_BANK  = 2'b10;
    localparam logic [15:0] WR_REQ_PTR   = 16'h0040;

endpackage

// File: rtl/batt_select_match.sv
// Module: batt_select_match
// Decides whether a Select record is the battery-connect form: reserved bank
// and pointer, length equal to the EPC length, and a mask equal to the EPC
// over that length. Purely combinational.
// Assumes: mask bit 0 lines up with EPC bit 0; bits at/above length ignored.
module batt_select_match
    import batt_assist_pkg::*;
#(
    parameter int MASK_W = 208,
    parameter int LEN_W  = 8
) (
    input  logic [1:0]        kind,
    input  logic [1:0]        bank,
    input  logic [15:0]       ptr,
    input  logic [LEN_W-1:0]  len,
    input  logic [MASK_W-1:0] mask,
    input  logic [MASK_W-1:0] epc,
    input  logic [LEN_W-1:0]  epc_len,
    output logic              hit
);

    logic [MASK_W-1:0] bit_ok;
    logic              len_fits;
    logic              hdr_ok;

    // Per-bit compare: a bit outside the length always passes.
    for (genvar i = 0; i < MASK_W; i++) begin : g_bit
        assign bit_ok[i] = (32'(len) <= 32'(i)) || (mask[i] == epc[i]);
    end

    // Header and length qualification.
    always_comb begin
        len_fits = (32'(len) <= 32'(MASK_W));
        hdr_ok   = (cmd_kind_e'(kind) == KIND_SELECT) &&
                   (bank == SEL_REQ_BANK) && (ptr == SEL_REQ_PTR);
    end

    // Full match only when header, length and every bit agree.
    assign hit = hdr_ok && len_fits && (len == epc_len) && (&bit_ok);

endmodule

// File: rtl/batt_write_match.sv
// Module: batt_write_match
// Decides whether a Write record is the battery-connect form: reserved bank
// and word pointer. The data word is deliberately not examined.
module batt_write_match
    import batt_assist_pkg::*;
(
    input  logic [1:0]  kind,
    input  logic [1:0]  bank,
    input  logic [15:0] ptr,
    input  logic [15:0] data,
    output logic        hit
);

    logic data_unused;

    // Data is a don't-care for this request form.
    assign data_unused = ^data;

    // Header match on kind, bank and pointer.
    assign hit = (cmd_kind_e'(kind) == KIND_WRITE) &&
                 (bank == WR_REQ_BANK) && (ptr == WR_REQ_PTR);

endmodule

// File: rtl/batt_connect_latch.sv
// Module: batt_connect_latch
// One-way flag set by a request and held until reset, plus a one-cycle pulse
// on the cycle the flag first goes high.
// Assumes: synchronous active-low reset.
module batt_connect_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic flag,
    output logic pulse
);

    // Set-only flag and first-set pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            pulse <= req && !flag;
            if (req) begin
                flag <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/batt_assist_request.sv
// Module: batt_assist_request (top)
// Watches parsed reader commands and sets a sticky battery-connect flag when
// either special Select or special Write form arrives with valid high. The
// flag is also patched into the protocol control word.
// Assumes: one record per cycle; tag_epc_len stays stable while records come.
module batt_assist_request #(
    parameter int EPC_WORDS     = 13,
    parameter int LEN_W         = 8,
    parameter int PC_STATUS_BIT = 4,
    localparam int MASK_W       = 16 * EPC_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [1:0]        cmd_bank,
    input  logic [15:0]       cmd_ptr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [MASK_W-1:0] cmd_mask,
    input  logic [15:0]       cmd_data,
    input  logic [MASK_W-1:0] tag_epc,
    input  logic [LEN_W-1:0]  tag_epc_len,
    input  logic [15:0]       pc_word_in,
    output logic              batt_connect,
    output logic              batt_connect_pulse,
    output logic [15:0]       pc_word_out
);

    logic sel_hit;
    logic wr_hit;
    logic req;

    batt_select_match #(
        .MASK_W (MASK_W),
        .LEN_W  (LEN_W)
    ) u_sel (
        .kind    (cmd_kind),
        .bank    (cmd_bank),
        .ptr     (cmd_ptr),
        .len     (cmd_len),
        .mask    (cmd_mask),
        .epc     (tag_epc),
        .epc_len (tag_epc_len),
        .hit     (sel_hit)
    );

    batt_write_match u_wr (
        .kind (cmd_kind),
        .bank (cmd_bank),
        .ptr  (cmd_ptr),
        .data (cmd_data),
        .hit  (wr_hit)
    );

    // A request needs the strobe and either form to match.
    assign req = cmd_valid && (sel_hit || wr_hit);

    batt_connect_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .flag  (batt_connect),
        .pulse (batt_connect_pulse)
    );

    // Patch the connection status into the control word.
    always_comb begin
        pc_word_out                = pc_word_in;
        pc_word_out[PC_STATUS_BIT] = batt_connect;
    end

endmodule

// File: rtl/batt_assist_request_chk.sv
// Module: batt_assist_request_chk
// Temporal checks on the top's ports, attached by bind.
module batt_assist_request_chk #(
    parameter int PC_STATUS_BIT = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [1:0]  cmd_kind,
    input logic [1:0]  cmd_bank,
    input logic        batt_connect,
    input logic        batt_connect_pulse,
    input logic [15:0] pc_word_in,
    input logic [15:0] pc_word_out
);

    logic past_ok;

    // Marks cycles that have a defined previous cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(batt_connect)) |-> batt_connect);

    assert_pulse_first_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (batt_connect_pulse == (batt_connect && !$past(batt_connect))));

    assert_invalid_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(cmd_valid) && !$past(batt_connect)) |-> !batt_connect);

    assert_write_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cmd_kind == 2'b10 && cmd_bank != 2'b10) && !$past(batt_connect))
        |-> !batt_connect);

    assert_select_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cmd_kind == 2'b01 && cmd_bank != 2'b11) && !$past(batt_connect))
        |-> !batt_connect);

    assert_pc_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pc_word_out ^ pc_word_in) & ~(16'h1 << PC_STATUS_BIT)) == 16'h0);

endmodule

bind batt_assist_request batt_assist_request_chk #(
    .PC_STATUS_BIT (PC_STATUS_BIT)
) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .cmd_valid          (cmd_valid),
    .cmd_kind           (cmd_kind),
    .cmd_bank           (cmd_bank),
    .batt_connect       (batt_connect),
    .batt_connect_pulse (batt_connect_pulse),
    .pc_word_in         (pc_word_in),
    .pc_word_out        (pc_word_out)
);

// File: tb/batt_assist_request_tb.sv
module batt_assist_request_tb;

    localparam int EPC_WORDS = 2;
    localparam int MASK_W    = 16 * EPC_WORDS;
    localparam int LEN_W     = 8;
    localparam int SBIT      = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_kind = 2'b00;
    logic [1:0]        cmd_bank = 2'b00;
    logic [15:0]       cmd_ptr = 16'h0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic [MASK_W-1:0] cmd_mask = '0;
    logic [15:0]       cmd_data = 16'h0;
    logic [MASK_W-1:0] tag_epc = 32'hA5C3_1E7B;
    logic [LEN_W-1:0]  tag_epc_len = 8'd32;
    logic [15:0]       pc_word_in = 16'h0;
    logic              batt_connect;
    logic              batt_connect_pulse;
    logic [15:0]       pc_word_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    batt_assist_request #(
        .EPC_WORDS     (EPC_WORDS),
        .LEN_W         (LEN_W),
        .PC_STATUS_BIT (SBIT)
    ) u_dut (
        .clk                (clk),
        .rst_n              (rst_n),
        .cmd_valid          (cmd_valid),
        .cmd_kind           (cmd_kind),
        .cmd_bank           (cmd_bank),
        .cmd_ptr            (cmd_ptr),
        .cmd_len            (cmd_len),
        .cmd_mask           (cmd_mask),
        .cmd_data           (cmd_data),
        .tag_epc            (tag_epc),
        .tag_epc_len        (tag_epc_len),
        .pc_word_in         (pc_word_in),
        .batt_connect       (batt_connect),
        .batt_connect_pulse (batt_connect_pulse),
        .pc_word_out        (pc_word_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; leaves the bench at a falling edge.
    task automatic do_reset();
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one record for one rising edge, then drop the strobe.
    task automatic send(input logic v, input logic [1:0] k, input logic [1:0] b,
                        input logic [15:0] p, input logic [LEN_W-1:0] l,
                        input logic [MASK_W-1:0] m, input logic [15:0] d);
        cmd_valid = v; cmd_kind = k; cmd_bank = b; cmd_ptr = p;
        cmd_len = l; cmd_mask = m; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        logic [15:0] ptrs [6];
        ptrs[0] = 16'h8140; ptrs[1] = 16'h0040; ptrs[2] = 16'h8141;
        ptrs[3] = 16'h0041; ptrs[4] = 16'h0140; ptrs[5] = 16'h0000;

        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1 flag", 32'(batt_connect), 0);
        check("R1 pulse", 32'(batt_connect_pulse), 0);
        check("R1 status bit", 32'(pc_word_out[SBIT]), 0);

        // R2 R4 R5 R6: header sweep with a correct full mask
        for (int k = 0; k < 4; k++)
            for (int v = 0; v < 2; v++)
                for (int b = 0; b < 4; b++)
                    for (int pi = 0; pi < 6; pi++) begin
                        logic exp_hit;
                        do_reset();
                        exp_hit = (v == 1) &&
                            ((k == 1 && b == 3 && ptrs[pi] == 16'h8140) ||
                             (k == 2 && b == 2 && ptrs[pi] == 16'h0040));
                        send(v[0], k[1:0], b[1:0], ptrs[pi], 8'd32, tag_epc,
                             16'(pi * 16'h1357 + k));
                        check("R2 R4 R5 R6 flag", 32'(batt_connect), 32'(exp_hit));
                        check("R8 pulse on set", 32'(batt_connect_pulse), 32'(exp_hit));
                        check("R9 status bit", 32'(pc_word_out[SBIT]), 32'(exp_hit));
                        @(negedge clk);
                        check("R8 pulse single", 32'(batt_connect_pulse), 0);
                        check("R7 flag held", 32'(batt_connect), 32'(exp_hit));
                    end

        // R3: length and per-bit mask sweep
        for (int ei = 0; ei < 4; ei++) begin
            int el;
            el = (ei == 0) ? 0 : (ei == 1) ? 5 : (ei == 2) ? 16 : 32;
            tag_epc_len = 8'(el);
            for (int cl = 0; cl <= 32; cl++)
                for (int f = -1; f < 32; f++) begin
                    logic [MASK_W-1:0] m;
                    logic exp_hit;
                    m = tag_epc;
                    if (f >= 0) m[f] = ~m[f];
                    exp_hit = (cl == el) && (f < 0 || f >= el);
                    do_reset();
                    send(1'b1, 2'b01, 2'b11, 16'h8140, 8'(cl), m, 16'h0);
                    check("R3 select mask", 32'(batt_connect), 32'(exp_hit));
                end
        end
        tag_epc_len = 8'd32;

        // R3: length beyond the mask width is rejected
        tag_epc_len = 8'd33;
        do_reset();
        send(1'b1, 2'b01, 2'b11, 16'h8140, 8'd33, tag_epc, 16'h0);
        check("R3 length over width", 32'(batt_connect), 0);
        tag_epc_len = 8'd32;

        // R4: write data values do not matter
        for (int d = 0; d < 16; d++) begin
            do_reset();
            send(1'b1, 2'b10, 2'b10, 16'h0040, 8'd0, '0, 16'(d * 16'h1111));
            check("R4 data ignored", 32'(batt_connect), 1);
        end

        // R7 R8: requests after set leave the flag high with no pulse
        do_reset();
        send(1'b1, 2'b10, 2'b10, 16'h0040, 8'd0, '0, 16'hBEEF);
        check("R8 first pulse", 32'(batt_connect_pulse), 1);
        send(1'b1, 2'b01, 2'b11, 16'h8140, 8'd32, tag_epc, 16'h0);
        check("R8 no repeat pulse sel", 32'(batt_connect_pulse), 0);
        check("R7 flag after sel", 32'(batt_connect), 1);
        send(1'b1, 2'b10, 2'b10, 16'h0040, 8'd0, '0, 16'h0);
        check("R8 no repeat pulse wr", 32'(batt_connect_pulse), 0);
        send(1'b1, 2'b11, 2'b00, 16'h0000, 8'd0, '0, 16'h0);
        check("R7 flag after other", 32'(batt_connect), 1);
        repeat (10) @(negedge clk);
        check("R7 flag idle", 32'(batt_connect), 1);

        // R9: pass-through of the other control word bits, flag both ways
        for (int fl = 0; fl < 2; fl++) begin
            do_reset();
            if (fl == 1) send(1'b1, 2'b10, 2'b10, 16'h0040, 8'd0, '0, 16'h0);
            for (int i = 0; i < 32; i++) begin
                logic [15:0] w;
                w = 16'(i * 16'h0B4D) ^ 16'(i << 9);
                pc_word_in = w;
                #1;
                check("R9 pc word", 32'(pc_word_out),
                      32'((w & ~(16'h1 << SBIT)) | (16'(fl) << SBIT)));
            end
            @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule